// File: doc/BRIEF.md
# Burst Capture FIFO with Half-Full Interrupt

This block buffers a stream of 8-bit samples that arrive in bursts from a data source, so that the processor does not have to take an interrupt per sample. Samples are written with a valid strobe and stored in order. The processor pops them with a read strobe. Empty, half-full and full flags report the fill level.

The interrupt request is held back until the fill level reaches half of the depth. After that it stays high, even as the level falls below half, until the reader has drained the FIFO to empty. The source may keep writing during the drain. A write that arrives while the buffer is full is discarded and sets a sticky overflow flag, which a dedicated clear input resets. The request arms again the next time the level reaches half.

Top module: `bfifo_top`

## Requirements
- R1: Samples are 8 bits wide and are read out in the order they were accepted. With the default depth of 16, sixteen samples can be held at once.
- R2: After any clock edge, `empty_o` is high exactly when no sample is held, `full_o` is high exactly when DEPTH samples are held, and `half_o` is high exactly when at least DEPTH/2 samples are held. `empty_o` and `full_o` are never high together.
- R3: A write strobe while `full_o` is high is discarded and leaves the held samples unchanged, even if a read happens in the same cycle. `ovf_o` is high after that edge.
- R4: `ovf_o` stays high until a cycle with `ovf_clr_i` high and no new discarded write. If a discarded write and `ovf_clr_i` occur in the same cycle, `ovf_o` stays set.
- R5: `irq_o` rises on the same edge on which the fill level first reaches DEPTH/2. It does not rise while the level is below DEPTH/2, so the first sample alone does not raise it.
- R6: Once high, `irq_o` stays high while the level drops below DEPTH/2. It falls on the same edge on which `empty_o` rises.
- R7: Writes are accepted during a drain. A read and a write in the same cycle, when the FIFO is neither empty nor full, leave the fill level and all flags unchanged and keep the data order.
- R8: A read strobe while empty is ignored. `rd_data_o` keeps its previous value and the pointers do not move. A write in that same cycle is still accepted, so a later read returns that sample.
- R9: After a drain to empty, `irq_o` asserts again as soon as the level again reaches DEPTH/2.
- R10: While `rst_ni` is low, `empty_o` is 1. `half_o`, `full_o`, `irq_o` and `ovf_o` are 0, and `rd_data_o` is 0.
- R11: An accepted read presents the popped sample on `rd_data_o` after the same clock edge. The value holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe from the data source |
| wr_data_i | input | 8 | Sample to store |
| rd_en_i | input | 1 | Read strobe from the processor |
| rd_data_o | output | 8 | Last popped sample (registered) |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| empty_o | output | 1 | No sample held |
| half_o | output | 1 | At least DEPTH/2 samples held |
| full_o | output | 1 | DEPTH samples held |
| irq_o | output | 1 | Interrupt request with half-full arm and empty release |
| ovf_o | output | 1 | Sticky flag: a write was discarded while full |

## Verification
The checker watches the interrupt hysteresis on every cycle. It checks that the request rises only with half-full, never drops before empty, and always covers half-full. It also checks the overflow set, hold and clear rules, the flag exclusions, the unchanged fill level on a combined read and write, and the unchanged read data on a read while empty. Some behaviour can only be shown by the bench's scenarios. These are the data order through full wrap-around, the absence of a discarded sample from the read stream, the re-arm after a drain, and a sample written while empty being returned later.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  localparam int unsigned SAMPLE_W = 8;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } level_flags_t;
endpackage

// File: rtl/bfifo_ptrs.sv
module bfifo_ptrs #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          wr_ok_o,
  output logic          rd_ok_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nxt_o
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          is_full, is_empty;

  assign is_full  = (count_q == CW'(DEPTH));
  assign is_empty = (count_q == '0);
  // full blocks writes even with a concurrent read; empty blocks reads
  assign wr_ok_o  = wr_req_i & ~is_full;
  assign rd_ok_o  = rd_req_i & ~is_empty;

  always_comb begin
    count_nxt_o = count_q;
    if (wr_ok_o && !rd_ok_o) count_nxt_o = count_q + CW'(1);
    else if (rd_ok_o && !wr_ok_o) count_nxt_o = count_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ok_o) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (rd_ok_o) rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_nxt_o;
    end
  end

  assign wr_addr_o = wr_ptr_q;
  assign rd_addr_o = rd_ptr_q;
  assign count_o   = count_q;
endmodule

// File: rtl/bfifo_store.sv
module bfifo_store #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [DEPTH];
  logic [DW-1:0] rdata_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk_i) begin
      if (sel) slot_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= slot_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bfifo_irq.sv
module bfifo_irq #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_nxt_i,
  input  logic          drop_i,
  input  logic          ovf_clr_i,
  output logic          irq_o,
  output logic          ovf_o
);
  logic irq_q, ovf_q;

  // arm at half, release only at empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (count_nxt_i >= CW'(HALF)) irq_q <= 1'b1;
    else if (count_nxt_i == '0) irq_q <= 1'b0;
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else if (drop_i) ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign irq_o = irq_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/bfifo_top.sv
module bfifo_top #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned DW   = bfifo_pkg::SAMPLE_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned HALF = DEPTH / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ovf_clr_i,
  output logic          empty_o,
  output logic          half_o,
  output logic          full_o,
  output logic          irq_o,
  output logic          ovf_o
);
  logic          wr_ok, rd_ok;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [CW-1:0] count_q, count_nxt;
  bfifo_pkg::level_flags_t flags;

  bfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_valid_i),
    .rd_req_i    (rd_en_i),
    .wr_ok_o     (wr_ok),
    .rd_ok_o     (rd_ok),
    .wr_addr_o   (wr_addr),
    .rd_addr_o   (rd_addr),
    .count_o     (count_q),
    .count_nxt_o (count_nxt)
  );

  bfifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok),
    .waddr_i (wr_addr),
    .wdata_i (wr_data_i),
    .re_i    (rd_ok),
    .raddr_i (rd_addr),
    .rdata_o (rd_data_o)
  );

  assign flags.empty = (count_q == '0);
  assign flags.half  = (count_q >= CW'(HALF));
  assign flags.full  = (count_q == CW'(DEPTH));

  bfifo_irq #(.DEPTH(DEPTH)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_nxt_i (count_nxt),
    .drop_i      (wr_valid_i & flags.full),
    .ovf_clr_i   (ovf_clr_i),
    .irq_o       (irq_o),
    .ovf_o       (ovf_o)
  );

  assign empty_o = flags.empty;
  assign half_o  = flags.half;
  assign full_o  = flags.full;
endmodule

// File: rtl/bfifo_checker.sv
module bfifo_checker #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          rd_en_i,
  input logic          ovf_clr_i,
  input logic          empty_o,
  input logic          half_o,
  input logic          full_o,
  input logic          irq_o,
  input logic          ovf_o,
  input logic [7:0]    rd_data_o,
  input logic [CW-1:0] count_i
);
  p_flag_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({empty_o, full_o}));
  p_full_half_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_valid_i && !rd_en_i |=> full_o && ovf_o);
  p_ovf_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);
  p_ovf_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i && !(wr_valid_i && full_o) |=> !ovf_o);
  p_irq_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> half_o);
  p_half_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_o |-> irq_o);
  p_irq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !empty_o |=> irq_o || empty_o);
  p_irq_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> empty_o);
  p_same_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && rd_en_i && !empty_o && !full_o |=> $stable(count_i));
  p_empty_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_en_i |=> $stable(rd_data_o));
endmodule

bind bfifo_top bfifo_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .rd_en_i    (rd_en_i),
  .ovf_clr_i  (ovf_clr_i),
  .empty_o    (empty_o),
  .half_o     (half_o),
  .full_o     (full_o),
  .irq_o      (irq_o),
  .ovf_o      (ovf_o),
  .rd_data_o  (rd_data_o),
  .count_i    (count_q)
);

// File: tb/bfifo_top_test.sv
`timescale 1ns/1ps
module bfifo_top_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       ovf_clr = 1'b0;
  logic [7:0] rd_data;
  logic       empty, half, full, irq, ovf;
  int         n_cmp = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  bfifo_top #(.DEPTH(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .ovf_clr_i(ovf_clr),
    .empty_o(empty), .half_o(half), .full_o(full), .irq_o(irq), .ovf_o(ovf)
  );

  typedef struct packed {
    logic       rd;     // 0: write burst, 1: read burst
    logic [4:0] n;
    logic [7:0] base;   // first written or expected sample
    logic       e, h, f, i;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd7,  8'h10, 1'b0, 1'b0, 1'b0, 1'b0},  // R5: below half, no irq
    '{1'b0, 5'd1,  8'h17, 1'b0, 1'b1, 1'b0, 1'b1},  // R5: reaches half
    '{1'b1, 5'd4,  8'h10, 1'b0, 1'b0, 1'b0, 1'b1},  // R6: held below half
    '{1'b0, 5'd2,  8'h18, 1'b0, 1'b0, 1'b0, 1'b1},  // R7: writes during drain
    '{1'b1, 5'd6,  8'h14, 1'b1, 1'b0, 1'b0, 1'b0},  // R6: released at empty
    '{1'b0, 5'd16, 8'h40, 1'b0, 1'b1, 1'b1, 1'b1},  // R9, R2: re-arm, full
    '{1'b1, 5'd16, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0}   // R1: order across wrap
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop(input logic [7:0] exp, input string req);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, "rd_data", int'(rd_data), int'(exp));
  endtask

  task automatic flags(input string req, input logic e, h, f, i);
    chk(req, "empty", int'(empty), int'(e));
    chk(req, "half",  int'(half),  int'(h));
    chk(req, "full",  int'(full),  int'(f));
    chk(req, "irq",   int'(irq),   int'(i));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    flags("R10", 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R10", "ovf", int'(ovf), 0);
    chk("R10", "rd_data", int'(rd_data), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // vector table: R1 R2 R5 R6 R7 R9 R11
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        if (VEC[v].rd) pop(VEC[v].base + 8'(k), "R11");
        else push(VEC[v].base + 8'(k));
      end
      flags($sformatf("R2 vec%0d", v), VEC[v].e, VEC[v].h, VEC[v].f, VEC[v].i);
    end

    // R3 and R4: overflow while full
    for (int k = 0; k < 16; k++) push(8'h60 + 8'(k));
    chk("R3", "ovf before", int'(ovf), 0);
    push(8'hEE);
    chk("R3", "ovf", int'(ovf), 1);
    chk("R3", "full", int'(full), 1);
    repeat (3) @(negedge clk);
    chk("R4", "ovf held", int'(ovf), 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R4", "ovf cleared", int'(ovf), 0);
    ovf_clr = 1'b1; push(8'hEF); ovf_clr = 1'b0;
    chk("R4", "ovf set wins", int'(ovf), 1);
    // R3: full with read and write together: write dropped
    wr_valid = 1'b1; wr_data = 8'hED; rd_en = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    chk("R3", "rd_data", int'(rd_data), 8'h60);
    chk("R3", "full after drop", int'(full), 0);
    for (int k = 1; k < 16; k++) pop(8'h60 + 8'(k), "R3");
    flags("R3 drained", 1'b1, 1'b0, 1'b0, 1'b0);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R4", "ovf final", int'(ovf), 0);

    // R8: read while empty
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R8", "rd_data held", int'(rd_data), 8'h6F);
    chk("R8", "empty", int'(empty), 1);
    wr_valid = 1'b1; wr_data = 8'h33; rd_en = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    chk("R8", "rd_data held w", int'(rd_data), 8'h6F);
    chk("R8", "empty after write", int'(empty), 0);
    pop(8'h33, "R8");
    chk("R8", "empty again", int'(empty), 1);

    // R7: read and write together mid-level
    for (int k = 0; k < 3; k++) push(8'h50 + 8'(k));
    wr_valid = 1'b1; wr_data = 8'h53; rd_en = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_en = 1'b0;
    chk("R7", "rd_data", int'(rd_data), 8'h50);
    flags("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 1; k < 4; k++) pop(8'h50 + 8'(k), "R7");
    flags("R7 end", 1'b1, 1'b0, 1'b0, 1'b0);

    // R6: irq falls exactly with empty
    for (int k = 0; k < 8; k++) push(8'h70 + 8'(k));
    for (int k = 0; k < 7; k++) pop(8'h70 + 8'(k), "R6");
    chk("R6", "irq one left", int'(irq), 1);
    pop(8'h77, "R6");
    chk("R6", "irq at empty", int'(irq), 0);

    done = 1'b1;
    summary();
  end
endmodule